// File: doc/BRIEF.md
# Polyphase Scaler Position Accumulator

This block produces, for one axis of a polyphase image scaler, the integer source sample index and the filter phase that each output sample needs. A fixed-point position register holds 13 fractional bits. It is loaded with a start offset at the beginning of every line or frame, and the increment is added to it after every output sample. The source index is the integer part of that position, and the 4-bit phase (one of 16) is the top four bits of the fraction.

The increment comes from a sequential restoring divider that forms the rounded ratio of source size to destination size in the same 13-bit fraction. Before dividing, a small siting stage halves the source size for chroma planes where the sampling format has fewer chroma samples. The same stage also picks a negative start offset that corrects 4:2:0 chroma siting. One parameter selects the horizontal or the vertical variant. Luma and chroma use the same hardware and differ only in the configuration inputs.

Top module: `scl_pos_gen`

## Requirements
- R1: After reset, and after a line start with `cfg_chroma`=0, the position is exactly zero: `src_idx`=0 and `phase`=0.
- R2: Each `step` pulse without `line_start` adds the current increment to the position. With neither pulse, the outputs hold.
- R3: `src_idx` is position bits [24:13] and `phase` is position bits [12:9], the top four of the 13 fractional bits, giving 16 phases.
- R4: A negative position gives `src_idx`=0, and the phase is still taken from the two's-complement fraction. A position of -2048 gives phase 12, and -4096 gives phase 8.
- R5: In the vertical variant, a chroma plane with `cfg_fmt`=0 (4:2:0) starts at -2048 for `cfg_site`=1 (quarter sample), at -4096 for `cfg_site`=2 (half sample), and at 0 for `cfg_site`=0.
- R6: In the horizontal variant, a 4:2:0 chroma plane starts at -2048 for `cfg_site`=1 and at 0 for any other site code.
- R7: Luma planes, and chroma planes with `cfg_fmt`=1 (4:2:2) or 2 (4:4:4), always start at 0.
- R8: The increment equals floor(((S << 13) + D/2) / D). S is the source size, halved for chroma in the horizontal variant when `cfg_fmt` is 0 or 1, and halved in the vertical variant only when `cfg_fmt` is 0. D is `dst_size`.
- R9: When the quotient exceeds 16 bits, or `dst_size`=0, the increment saturates to 16'hFFFF.
- R10: `calc_done` is a one-cycle pulse exactly 26 clock edges after the edge that accepted `calc_go`. A `calc_go` raised while `calc_busy` is high is ignored.
- R11: When `line_start` and `step` are high in the same cycle, the position is loaded with the start offset and nothing is added.
- R12: A new increment takes effect at the edge that raises `calc_done`, and later steps use it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_chroma | input | 1 | 1 selects a chroma plane, 0 selects luma |
| cfg_fmt | input | 2 | Source sampling: 0 = 4:2:0, 1 = 4:2:2, 2 = 4:4:4 |
| cfg_site | input | 2 | Chroma siting: 0 = co-sited, 1 = quarter sample, 2 = half sample |
| src_size | input | 12 | Source size along the axis, in luma samples |
| dst_size | input | 12 | Destination size along the axis |
| calc_go | input | 1 | Starts an increment calculation |
| calc_busy | output | 1 | Divider is running |
| calc_done | output | 1 | One-cycle pulse when a new increment is ready |
| calc_inc | output | 16 | Current increment, with 13 fractional bits |
| line_start | input | 1 | Loads the start offset into the position |
| step | input | 1 | Advances the position by one output sample |
| src_idx | output | 12 | Integer source index, clamped to 0 when the position is negative |
| phase | output | 4 | Filter phase index |

## Verification
The position outputs are driven from one register, so they change one edge after a `line_start` or `step` is sampled. The increment and `calc_done` appear 26 edges after the edge that accepted `calc_go`. The bench drives every input on the falling edge and samples on the following falling edge, half a cycle after the updating edge. For each division it counts edges from acceptance until `calc_done`, and it requires exactly 26, then checks that the pulse has gone one cycle later.

// File: rtl/scl_pos_pkg.sv
package scl_pos_pkg;
   typedef enum logic [1:0] {
      FMT_420 = 2'd0,
      FMT_422 = 2'd1,
      FMT_444 = 2'd2
   } smp_fmt_e;

   typedef enum logic [1:0] {
      SITE_ZERO    = 2'd0,
      SITE_QUARTER = 2'd1,
      SITE_HALF    = 2'd2
   } site_e;
endpackage

// File: rtl/scl_siting.sv
module scl_siting
   import scl_pos_pkg::*;
#(
   parameter bit VERTICAL = 1'b0,
   parameter int FRAC_W   = 13,
   parameter int START_W  = 19,
   parameter int SIZE_W   = 12
) (
   input  logic                      chroma,
   input  smp_fmt_e                  fmt,
   input  site_e                     site,
   input  logic [SIZE_W-1:0]         src_in,
   output logic signed [START_W-1:0] start_val,
   output logic [SIZE_W-1:0]         src_eff
);
   localparam logic [START_W-1:0] OFS_QUARTER = START_W'(-(1 <<< (FRAC_W - 2)));
   localparam logic [START_W-1:0] OFS_HALF    = START_W'(-(1 <<< (FRAC_W - 1)));

   logic sub420;
   assign sub420 = chroma && (fmt == FMT_420);

   generate
      if (VERTICAL) begin : g_vert
         always_comb begin
            start_val = '0;
            if (sub420 && site == SITE_QUARTER) start_val = OFS_QUARTER;
            else if (sub420 && site == SITE_HALF) start_val = OFS_HALF;
            src_eff = sub420 ? (src_in >> 1) : src_in;
         end
      end else begin : g_horz
         always_comb begin
            start_val = (sub420 && site == SITE_QUARTER) ? OFS_QUARTER : '0;
            src_eff = (chroma && (fmt == FMT_420 || fmt == FMT_422)) ? (src_in >> 1) : src_in;
         end
      end
   endgenerate
endmodule

// File: rtl/scl_inc_div.sv
module scl_inc_div #(
   parameter int SIZE_W = 12,
   parameter int FRAC_W = 13,
   parameter int INC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [SIZE_W-1:0] num_size,
   input  logic [SIZE_W-1:0] den_size,
   output logic              busy,
   output logic              done,
   output logic [INC_W-1:0]  quot
);
   localparam int NUM_W = SIZE_W + FRAC_W + 1;
   localparam int CNT_W = $clog2(NUM_W + 1);

   if (NUM_W <= INC_W) begin : g_bad_width
      $error("scl_inc_div: dividend must be wider than the increment");
   end

   logic [NUM_W-1:0]  quo_q, quo_nxt, numer;
   logic [SIZE_W:0]   rem_q, trial;
   logic [SIZE_W-1:0] den_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q, done_q, fits;
   logic [INC_W-1:0]  res_q;

   assign numer   = {1'b0, num_size, {FRAC_W{1'b0}}} + NUM_W'(den_size >> 1);
   assign trial   = {rem_q[SIZE_W-1:0], quo_q[NUM_W-1]};
   assign fits    = trial >= {1'b0, den_q};
   assign quo_nxt = {quo_q[NUM_W-2:0], fits};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q  <= '0;
         rem_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         res_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (go && !busy_q) begin
            quo_q  <= numer;
            rem_q  <= '0;
            den_q  <= den_size;
            cnt_q  <= '0;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            rem_q <= fits ? (trial - {1'b0, den_q}) : trial;
            quo_q <= quo_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(NUM_W - 1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               res_q  <= (|quo_nxt[NUM_W-1:INC_W]) ? '1 : quo_nxt[INC_W-1:0];
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign quot = res_q;

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ($past(busy_q) && !busy_q));
   assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> $stable(res_q));
endmodule

// File: rtl/scl_pos_acc.sv
module scl_pos_acc #(
   parameter int FRAC_W  = 13,
   parameter int PHASE_W = 4,
   parameter int IDX_W   = 12,
   parameter int START_W = 19,
   parameter int INC_W   = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic signed [START_W-1:0] start_val,
   input  logic                      step,
   input  logic [INC_W-1:0]          inc,
   output logic [IDX_W-1:0]          src_idx,
   output logic [PHASE_W-1:0]        phase
);
   localparam int POS_W = IDX_W + FRAC_W + 1;

   if (PHASE_W > FRAC_W) begin : g_bad_phase
      $error("scl_pos_acc: phase wider than fraction");
   end
   if (START_W > POS_W || INC_W >= POS_W) begin : g_bad_pos
      $error("scl_pos_acc: position register too narrow");
   end

   logic signed [POS_W-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (load) begin
         pos_q <= {{(POS_W-START_W){start_val[START_W-1]}}, start_val};
      end else if (step) begin
         pos_q <= pos_q + {{(POS_W-INC_W){1'b0}}, inc};
      end
   end

   assign src_idx = pos_q[POS_W-1] ? '0 : pos_q[FRAC_W +: IDX_W];
   assign phase   = pos_q[FRAC_W-1 -: PHASE_W];

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> ($stable(src_idx) && $stable(phase)));
endmodule

// File: rtl/scl_pos_gen.sv
module scl_pos_gen
   import scl_pos_pkg::*;
#(
   parameter bit VERTICAL  = 1'b0,
   parameter int FRAC_W    = 13,
   parameter int PHASE_W   = 4,
   parameter int SIZE_W    = 12,
   parameter int INC_W     = 16,
   parameter int H_START_W = 19,
   parameter int V_START_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_chroma,
   input  logic [1:0]         cfg_fmt,
   input  logic [1:0]         cfg_site,
   input  logic [SIZE_W-1:0]  src_size,
   input  logic [SIZE_W-1:0]  dst_size,
   input  logic               calc_go,
   output logic               calc_busy,
   output logic               calc_done,
   output logic [INC_W-1:0]   calc_inc,
   input  logic               line_start,
   input  logic               step,
   output logic [SIZE_W-1:0]  src_idx,
   output logic [PHASE_W-1:0] phase
);
   localparam int START_W = VERTICAL ? V_START_W : H_START_W;

   if (START_W < FRAC_W) begin : g_bad_start
      $error("scl_pos_gen: start offset cannot hold a half-sample shift");
   end

   logic signed [START_W-1:0] start_val;
   logic [SIZE_W-1:0]         src_eff;

   scl_siting #(
      .VERTICAL(VERTICAL), .FRAC_W(FRAC_W), .START_W(START_W), .SIZE_W(SIZE_W)
   ) u_siting (
      .chroma(cfg_chroma), .fmt(smp_fmt_e'(cfg_fmt)), .site(site_e'(cfg_site)),
      .src_in(src_size), .start_val(start_val), .src_eff(src_eff)
   );

   scl_inc_div #(
      .SIZE_W(SIZE_W), .FRAC_W(FRAC_W), .INC_W(INC_W)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .go(calc_go), .num_size(src_eff),
      .den_size(dst_size), .busy(calc_busy), .done(calc_done), .quot(calc_inc)
   );

   scl_pos_acc #(
      .FRAC_W(FRAC_W), .PHASE_W(PHASE_W), .IDX_W(SIZE_W),
      .START_W(START_W), .INC_W(INC_W)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .load(line_start), .start_val(start_val),
      .step(step), .inc(calc_inc), .src_idx(src_idx), .phase(phase)
   );

   assert_luma_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !cfg_chroma) |=> (src_idx == '0 && phase == '0));
   assert_no_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && cfg_fmt != 2'd0) |=> (src_idx == '0 && phase == '0));
   assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && step && !cfg_chroma) |=> (src_idx == '0 && phase == '0));
   assert_busy_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      calc_done |-> !calc_busy);
endmodule

// File: tb/tb_scl_pos_gen.sv
`timescale 1ns/1ps
module tb_scl_pos_gen;
   localparam int NUM_W = 26;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_chroma = 1'b0;
   logic [1:0]  cfg_fmt = 2'd2;
   logic [1:0]  cfg_site = 2'd0;
   logic [11:0] src_size = '0, dst_size = '0;
   logic        calc_go = 1'b0, line_start = 1'b0, step = 1'b0;

   logic        h_busy, h_done, v_busy, v_done;
   logic [15:0] h_inc, v_inc;
   logic [11:0] h_idx, v_idx;
   logic [3:0]  h_ph, v_ph;

   int checks = 0;
   int errors = 0;
   longint pos_h = 0, pos_v = 0, inc_h = 0, inc_v = 0;

   always #2 clk = ~clk;

   scl_pos_gen #(.VERTICAL(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_chroma(cfg_chroma), .cfg_fmt(cfg_fmt),
      .cfg_site(cfg_site), .src_size(src_size), .dst_size(dst_size),
      .calc_go(calc_go), .calc_busy(h_busy), .calc_done(h_done), .calc_inc(h_inc),
      .line_start(line_start), .step(step), .src_idx(h_idx), .phase(h_ph));

   scl_pos_gen #(.VERTICAL(1'b1)) dut_v (
      .clk(clk), .rst_n(rst_n), .cfg_chroma(cfg_chroma), .cfg_fmt(cfg_fmt),
      .cfg_site(cfg_site), .src_size(src_size), .dst_size(dst_size),
      .calc_go(calc_go), .calc_busy(v_busy), .calc_done(v_done), .calc_inc(v_inc),
      .line_start(line_start), .step(step), .src_idx(v_idx), .phase(v_ph));

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic longint exp_src(bit vert, longint s);
      if (!cfg_chroma) return s;
      if (vert) return (cfg_fmt == 2'd0) ? (s >> 1) : s;
      return (cfg_fmt == 2'd0 || cfg_fmt == 2'd1) ? (s >> 1) : s;
   endfunction

   function automatic longint exp_start(bit vert);
      if (!cfg_chroma || cfg_fmt != 2'd0) return 0;
      if (cfg_site == 2'd1) return -2048;
      if (vert && cfg_site == 2'd2) return -4096;
      return 0;
   endfunction

   function automatic longint exp_inc(longint s, longint d);
      longint q;
      if (d == 0) return 65535;
      q = ((s << 13) + d / 2) / d;
      return (q > 65535) ? 65535 : q;
   endfunction

   function automatic longint ex_idx(longint p);
      return (p < 0) ? 0 : (p >>> 13);
   endfunction

   function automatic longint ex_ph(longint p);
      return (p & 64'h1FFF) >> 9;
   endfunction

   task automatic chk_pos(string req);
      chk(req, "h src_idx", h_idx, ex_idx(pos_h));
      chk(req, "h phase", h_ph, ex_ph(pos_h));
      chk(req, "v src_idx", v_idx, ex_idx(pos_v));
      chk(req, "v phase", v_ph, ex_ph(pos_v));
   endtask

   // runs one division; interferes with a second go at cycle 3 when asked
   task automatic run_div(string req, int s, int d, bit poke);
      int n = 0;
      longint eh, ev;
      src_size = 12'(s); dst_size = 12'(d);
      eh = exp_inc(exp_src(1'b0, s), d);
      ev = exp_inc(exp_src(1'b1, s), d);
      calc_go = 1'b1;
      @(posedge clk); @(negedge clk);
      calc_go = 1'b0;
      while (!h_done && n < 100) begin
         if (poke && n == 3) begin
            calc_go = 1'b1; src_size = 12'd7; dst_size = 12'd3;
         end else calc_go = 1'b0;
         @(posedge clk); @(negedge clk);
         n++;
      end
      calc_go = 1'b0;
      chk("R10", "done latency", n, NUM_W);
      chk("R10", "v done aligned", v_done, 1);
      chk("R10", "busy low at done", h_busy, 0);
      chk(req, "h increment", h_inc, eh);
      chk(req, "v increment", v_inc, ev);
      inc_h = eh; inc_v = ev;
      @(negedge clk);
      chk("R10", "done one cycle", h_done, 0);
   endtask

   task automatic restart(string req);
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      pos_h = exp_start(1'b0); pos_v = exp_start(1'b1);
      chk_pos(req);
   endtask

   task automatic steps(string req, int n);
      for (int i = 0; i < n; i++) begin
         step = 1'b1;
         @(negedge clk);
         step = 1'b0;
         pos_h += inc_h; pos_v += inc_v;
         chk_pos(req);
         @(negedge clk);
         chk_pos("R2");
      end
   endtask

   task automatic t_reset;
      chk("R1", "reset h idx", h_idx, 0);
      chk("R1", "reset v phase", v_ph, 0);
      chk("R10", "reset busy", h_busy, 0);
      chk("R10", "reset done", h_done, 0);
   endtask

   task automatic t_luma;
      cfg_chroma = 1'b0; cfg_fmt = 2'd2; cfg_site = 2'd1;
      run_div("R8", 1920, 1280, 1'b0);
      restart("R1");
      steps("R3", 5);
      run_div("R8", 720, 1920, 1'b0);
      steps("R12", 3);
      restart("R1");
      steps("R2", 7);
   endtask

   task automatic t_chroma420;
      cfg_chroma = 1'b1; cfg_fmt = 2'd0; cfg_site = 2'd1;
      run_div("R8", 1920, 1080, 1'b0);
      restart("R4");
      chk("R5", "v quarter phase", v_ph, 12);
      chk("R6", "h quarter phase", h_ph, 12);
      steps("R4", 4);
      cfg_site = 2'd2;
      restart("R5");
      chk("R5", "v half phase", v_ph, 8);
      chk("R6", "h half gives zero", h_ph, 0);
      steps("R4", 3);
      cfg_site = 2'd0;
      restart("R5");
   endtask

   task automatic t_other_fmt;
      cfg_chroma = 1'b1; cfg_fmt = 2'd1; cfg_site = 2'd1;
      run_div("R8", 1280, 1000, 1'b0);
      restart("R7");
      steps("R2", 2);
      cfg_fmt = 2'd2; cfg_site = 2'd2;
      run_div("R8", 1280, 1000, 1'b0);
      restart("R7");
   endtask

   task automatic t_saturate;
      cfg_chroma = 1'b0; cfg_fmt = 2'd2;
      run_div("R9", 4095, 1, 1'b0);
      run_div("R9", 100, 0, 1'b0);
   endtask

   task automatic t_busy_go;
      cfg_chroma = 1'b0;
      run_div("R10", 1000, 600, 1'b1);
   endtask

   task automatic t_priority;
      cfg_chroma = 1'b1; cfg_fmt = 2'd0; cfg_site = 2'd2;
      restart("R11");
      steps("R11", 2);
      line_start = 1'b1; step = 1'b1;
      @(negedge clk);
      line_start = 1'b0; step = 1'b0;
      pos_h = exp_start(1'b0); pos_v = exp_start(1'b1);
      chk_pos("R11");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_luma();
      t_chroma420();
      t_other_fmt();
      t_saturate();
      t_busy_go();
      t_priority();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule